// File: doc/BRIEF.md
# DDR2 Bank Transaction and Refresh Sequencer

This block sits between a request queue and a DDR2 PHY for a four-bank, 16-bit-wide device. It takes one decoded request at a time (a single-word or a multi-burst transfer) and turns it into the row-open, column-access and row-close command stream the memory needs. It also schedules its own periodic auto refresh. A set of down-counters loaded from the timing parameters spaces the commands. The column-access strobe, the row-open delay, the minimum row-active time, the row-close time and the refresh busy time each have their own parameter.

Each transfer opens one row, issues one to four eight-beat column commands, and then closes the row. On a write, the block tells the PHY when to pop a burst of write data and which beats to mask. On a read, it predicts in which cycles the returned words arrive and tags each one with the word address it belongs to. Only one row is open at any time, and a refresh is started only from the idle state, after all banks have been precharged.

Top module: `dram_txn_engine`

## Requirements
- R1: The 25-bit word address splits as bank = bits 24:23, row = bits 22:10 and column = bits 9:0. The command outputs are encoded NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4 and REFRESH=5.
- R2: A request is accepted at a clock edge where `reqValid` and `reqReady` are both high. The ACTIVATE, carrying that bank and row, is on the command outputs in the next cycle. `reqOp` is encoded 0 single read, 1 single write, 2 block read, 3 block write.
- R3: The first column command comes exactly TRCD cycles after the ACTIVATE. It carries the column with its three low bits cleared, and address bit 10 is low.
- R4: A block request issues `reqBursts`+1 column commands, spaced exactly 8 cycles apart, with the column rising by 8 each time. The three low address bits of a block request are ignored.
- R5: The closing PRECHARGE (address bit 10 low, the same bank) comes in the first cycle that is at least TRAS after the ACTIVATE and at least 8 cycles after the last READ, or at least 8+TWR cycles after the last WRITE.
- R6: `reqReady` is high only in the idle state with no refresh pending. A new ACTIVATE is at least TRP cycles after the previous PRECHARGE.
- R7: Every WRITE command has `wrPop` high in the same cycle. A single write masks the seven unused beats: `dataMask` bit i is high for every beat i except the addressed beat, which is address bits 2:0. A block write has a mask of zero, and `dataMask` is zero for all other commands.
- R8: A single read yields exactly one `retValid` cycle, CL cycles after its READ, with `retTag` equal to the request address. A block read yields 8 consecutive `retValid` cycles per READ, starting CL cycles after it, with tags counting up from the burst's aligned address.
- R9: A refresh becomes pending every TREFI cycles. When the block is idle it issues PRECHARGE with address bit 10 high (all banks), then REFRESH exactly TRP cycles later. In an otherwise idle period, successive REFRESH commands are TREFI cycles apart.
- R10: After a REFRESH, `reqReady` stays low for TRFC cycles. A request held waiting is accepted TRFC cycles after the REFRESH.
- R11: After reset the command output is NOP, `reqReady` is high, and `retValid`, `wrPop` and `dataMask` are zero.
- R12: At most one command is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is offered |
| reqOp | input | 2 | Operation: bit 1 block, bit 0 write |
| reqAddr | input | 25 | Word address of the request |
| reqBursts | input | 2 | Number of bursts minus one (block only) |
| reqReady | output | 1 | The engine accepts a request this cycle |
| cmdCode | output | 3 | DRAM command toward the PHY |
| cmdBank | output | 2 | Bank of the command |
| cmdAddr | output | 13 | Row or column address; bit 10 selects all banks or auto-precharge |
| dataMask | output | 8 | Per-beat write mask, 1 = beat masked |
| wrPop | output | 1 | Pop one burst of write data |
| retValid | output | 1 | A read word is expected this cycle |
| retTag | output | 25 | Word address of the expected read word |

## Verification
The spacing assertions assume that every timing parameter lies between 1 and 254, because the checker counters saturate at 255. They also assume that CL is at least 1. The request fields are sampled only at the accepting edge, so the bench holds them steady from the cycle it raises `reqValid` until it sees `reqReady`. The bench then waits until the row is closed before the next scenario. Refresh can arrive at any point in a run. For this reason the bench predicts command cycles relative to the observed acceptance cycle rather than absolute time, and it checks refresh spacing only across REFRESH commands issued while the block is idle.

// File: rtl/dram_seq_pkg.sv
`timescale 1ns/1ps
package dram_seq_pkg;

  localparam int BURST_BEATS = 8;
  localparam int ADDR_W = 25;
  localparam int BANK_W = 2;
  localparam int ROW_W = 13;
  localparam int COL_W = 10;

  typedef enum logic [2:0] {
    CMD_NOP     = 3'd0,
    CMD_ACT     = 3'd1,
    CMD_READ    = 3'd2,
    CMD_WRITE   = 3'd3,
    CMD_PRE     = 3'd4,
    CMD_REFRESH = 3'd5
  } dramCmd_t;

  // control -> datapath strobes, one cycle ahead of the command outputs
  typedef struct packed {
    logic load;
    logic act;
    logic col;
    logic pre;
    logic preAll;
    logic refresh;
  } seqStrobe_t;

  typedef struct packed {
    logic v;
    logic scalar;
    logic [ADDR_W-1:0] tag;
  } retSlot_t;

endpackage

// File: rtl/dram_seq_ctrl.sv
`timescale 1ns/1ps
module dram_seq_ctrl
  import dram_seq_pkg::*;
#(
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TRAS  = 12,
  parameter int TRFC  = 14,
  parameter int TWR   = 3,
  parameter int TREFI = 300
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic [1:0] reqBursts,
  output logic       reqReady,
  output seqStrobe_t stb
);

  localparam int WR_REC = BURST_BEATS + TWR;
  localparam int MAX_A = (TRFC > TRAS) ? TRFC : TRAS;
  localparam int MAX_B = (WR_REC > TRP) ? WR_REC : TRP;
  localparam int MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T = (MAX_C > TRCD) ? MAX_C : TRCD;
  localparam int TW = $clog2(MAX_T + 1);
  localparam int RW = $clog2(TRAS + 1);
  localparam int FW = $clog2(TREFI + 1);

  typedef enum logic [2:0] {S_IDLE, S_XFER, S_RECOV, S_PREW, S_REFP, S_RFCW} seqState_t;

  seqState_t state, nxtState;
  logic [TW-1:0] timer;
  logic [RW-1:0] rasCnt;
  logic [FW-1:0] refCnt;
  logic          refPend;
  logic [1:0]    burstsLeft;
  logic          isWrite;

  assign reqReady = (state == S_IDLE) && !refPend;

  always_comb begin
    stb = '0;
    nxtState = state;
    unique case (state)
      S_IDLE: begin
        if (refPend) begin
          stb.preAll = 1'b1;
          nxtState = S_REFP;
        end else if (reqValid) begin
          stb.load = 1'b1;
          stb.act = 1'b1;
          nxtState = S_XFER;
        end
      end
      S_XFER: begin
        if (timer == '0) begin
          stb.col = 1'b1;
          if (burstsLeft == 2'd0) nxtState = S_RECOV;
        end
      end
      S_RECOV: begin
        if (timer == '0 && rasCnt == '0) begin
          stb.pre = 1'b1;
          nxtState = S_PREW;
        end
      end
      S_PREW: if (timer == '0) nxtState = S_IDLE;
      S_REFP: begin
        if (timer == '0) begin
          stb.refresh = 1'b1;
          nxtState = S_RFCW;
        end
      end
      S_RFCW: if (timer == '0) nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      timer <= '0;
      rasCnt <= '0;
      burstsLeft <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= nxtState;
      if (stb.act) timer <= TW'(TRCD - 1);
      else if (stb.col) timer <= (burstsLeft != 2'd0) ? TW'(BURST_BEATS - 1)
                                 : (isWrite ? TW'(WR_REC - 1) : TW'(BURST_BEATS - 1));
      else if (stb.pre || stb.preAll) timer <= TW'(TRP - 1);
      else if (stb.refresh) timer <= TW'(TRFC - 1);
      else if (timer != '0) timer <= timer - 1'b1;

      if (stb.act) rasCnt <= RW'(TRAS - 1);
      else if (rasCnt != '0) rasCnt <= rasCnt - 1'b1;

      if (stb.load) begin
        burstsLeft <= reqOp[1] ? reqBursts : 2'd0;
        isWrite <= reqOp[0];
      end else if (stb.col && burstsLeft != 2'd0) begin
        burstsLeft <= burstsLeft - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt <= FW'(TREFI - 1);
      refPend <= 1'b0;
    end else begin
      if (refCnt == '0) refCnt <= FW'(TREFI - 1);
      else refCnt <= refCnt - 1'b1;
      if (refCnt == '0) refPend <= 1'b1;
      else if (stb.refresh) refPend <= 1'b0;
    end
  end

  // R12
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.act, stb.col, stb.pre, stb.preAll, stb.refresh}));

  // R6
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |-> reqValid && !refPend);

endmodule

// File: rtl/dram_seq_dp.sv
`timescale 1ns/1ps
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int CL = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         stb,
  input  logic [1:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [2:0]         cmdCode,
  output logic [BANK_W-1:0]  cmdBank,
  output logic [ROW_W-1:0]   cmdAddr,
  output logic [BURST_BEATS-1:0] dataMask,
  output logic               wrPop,
  output logic               retValid,
  output logic [ADDR_W-1:0]  retTag
);

  localparam int BEAT_W = $clog2(BURST_BEATS);

  dramCmd_t cmdR;
  logic [BANK_W-1:0] bankR;
  logic [ROW_W-1:0]  rowR;
  logic [COL_W-1:0]  colR;
  logic [1:0]        opR;
  logic [ADDR_W-1:0] issueTag;
  logic              issueScalar;
  retSlot_t          rdLine [CL];
  retSlot_t          lineOut;
  logic [BEAT_W-1:0] beatsLeft;
  logic [ADDR_W-1:0] nextTag;

  assign cmdCode = cmdR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankR <= '0;
      rowR <= '0;
      colR <= '0;
      opR <= '0;
      issueTag <= '0;
      issueScalar <= 1'b0;
    end else begin
      if (stb.load) begin
        bankR <= reqAddr[ADDR_W-1 -: BANK_W];
        rowR <= reqAddr[COL_W +: ROW_W];
        colR <= reqOp[1] ? {reqAddr[COL_W-1:BEAT_W], BEAT_W'(0)} : reqAddr[COL_W-1:0];
        opR <= reqOp;
      end else if (stb.col) begin
        colR[COL_W-1:BEAT_W] <= colR[COL_W-1:BEAT_W] + 1'b1;
      end
      if (stb.col) begin
        issueTag <= {bankR, rowR, colR};
        issueScalar <= !opR[1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdR <= CMD_NOP;
      cmdBank <= '0;
      cmdAddr <= '0;
      dataMask <= '0;
      wrPop <= 1'b0;
    end else begin
      cmdR <= CMD_NOP;
      cmdAddr <= '0;
      dataMask <= '0;
      wrPop <= 1'b0;
      if (stb.act) begin
        cmdR <= CMD_ACT;
        cmdBank <= reqAddr[ADDR_W-1 -: BANK_W];
        cmdAddr <= reqAddr[COL_W +: ROW_W];
      end else if (stb.col) begin
        cmdR <= opR[0] ? CMD_WRITE : CMD_READ;
        cmdBank <= bankR;
        cmdAddr <= ROW_W'({colR[COL_W-1:BEAT_W], BEAT_W'(0)});
        wrPop <= opR[0];
        if (opR[0] && !opR[1]) dataMask <= ~(BURST_BEATS'(1) << colR[BEAT_W-1:0]);
      end else if (stb.pre) begin
        cmdR <= CMD_PRE;
        cmdBank <= bankR;
      end else if (stb.preAll) begin
        cmdR <= CMD_PRE;
        cmdBank <= '0;
        cmdAddr <= ROW_W'(1) << 10;
      end else if (stb.refresh) begin
        cmdR <= CMD_REFRESH;
        cmdBank <= '0;
      end
    end
  end

  // read-return prediction: CL-deep line fed by the issued READ
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CL; i++) rdLine[i] <= '0;
    end else begin
      rdLine[0] <= '{v: (cmdR == CMD_READ), scalar: issueScalar, tag: issueTag};
      for (int i = 1; i < CL; i++) rdLine[i] <= rdLine[i-1];
    end
  end

  assign lineOut = rdLine[CL-1];
  assign retValid = lineOut.v || (beatsLeft != '0);
  assign retTag = lineOut.v ? lineOut.tag : nextTag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatsLeft <= '0;
      nextTag <= '0;
    end else begin
      nextTag <= retTag + 1'b1;
      if (lineOut.v) beatsLeft <= lineOut.scalar ? '0 : BEAT_W'(BURST_BEATS - 1);
      else if (beatsLeft != '0) beatsLeft <= beatsLeft - 1'b1;
    end
  end

  // R7
  pop_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPop || dataMask != '0) |-> cmdR == CMD_WRITE);

  // R8
  tag_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (retValid && $past(retValid) && !lineOut.v) |-> retTag == $past(retTag) + 1'b1);

endmodule

// File: rtl/dram_txn_engine.sv
`timescale 1ns/1ps
module dram_txn_engine
  import dram_seq_pkg::*;
#(
  parameter int TRCD  = 3,
  parameter int TRP   = 3,
  parameter int TRAS  = 12,
  parameter int TRFC  = 14,
  parameter int TWR   = 3,
  parameter int TREFI = 300,
  parameter int CL    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqOp,
  input  logic [24:0] reqAddr,
  input  logic [1:0]  reqBursts,
  output logic        reqReady,
  output logic [2:0]  cmdCode,
  output logic [1:0]  cmdBank,
  output logic [12:0] cmdAddr,
  output logic [7:0]  dataMask,
  output logic        wrPop,
  output logic        retValid,
  output logic [24:0] retTag
);

  seqStrobe_t stb;

  dram_seq_ctrl #(
    .TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRFC(TRFC), .TWR(TWR), .TREFI(TREFI)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .reqBursts(reqBursts), .reqReady(reqReady), .stb(stb)
  );

  dram_seq_dp #(.CL(CL)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqOp(reqOp), .reqAddr(reqAddr),
    .cmdCode(cmdCode), .cmdBank(cmdBank), .cmdAddr(cmdAddr),
    .dataMask(dataMask), .wrPop(wrPop), .retValid(retValid), .retTag(retTag)
  );

  // spacing monitors on the command outputs, saturating at 255
  logic [7:0] sinceAct, sincePre, sinceRef, sinceRd, sinceWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceAct <= 8'hFF;
      sincePre <= 8'hFF;
      sinceRef <= 8'hFF;
      sinceRd <= 8'hFF;
      sinceWr <= 8'hFF;
    end else begin
      sinceAct <= (cmdCode == CMD_ACT) ? 8'd1 : sinceAct + {7'd0, sinceAct != 8'hFF};
      sincePre <= (cmdCode == CMD_PRE) ? 8'd1 : sincePre + {7'd0, sincePre != 8'hFF};
      sinceRef <= (cmdCode == CMD_REFRESH) ? 8'd1 : sinceRef + {7'd0, sinceRef != 8'hFF};
      sinceRd <= (cmdCode == CMD_READ) ? 8'd1 : sinceRd + {7'd0, sinceRd != 8'hFF};
      sinceWr <= (cmdCode == CMD_WRITE) ? 8'd1 : sinceWr + {7'd0, sinceWr != 8'hFF};
    end
  end

  // R3
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_READ || cmdCode == CMD_WRITE) |-> sinceAct >= 8'(TRCD));

  // R5
  ras_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_PRE && !cmdAddr[10]) |-> sinceAct >= 8'(TRAS));

  // R5
  wr_recov_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_PRE) |-> (sinceWr >= 8'(BURST_BEATS + TWR) && sinceRd >= 8'(BURST_BEATS)));

  // R6
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_ACT || cmdCode == CMD_REFRESH) |-> sincePre >= 8'(TRP));

  // R10
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdCode == CMD_ACT) |-> sinceRef >= 8'(TRFC));

endmodule

// File: tb/test_dram_txn_engine.sv
`timescale 1ns/1ps
module test_dram_txn_engine;

  localparam int TRCD = 3, TRP = 3, TRAS = 12, TRFC = 14, TWR = 3, TREFI = 300, CL = 4;
  localparam int BEAT = 8;
  localparam int NLOG = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqOp = '0;
  logic [24:0] reqAddr = '0;
  logic [1:0] reqBursts = '0;
  logic reqReady, wrPop, retValid;
  logic [2:0] cmdCode;
  logic [1:0] cmdBank;
  logic [12:0] cmdAddr;
  logic [7:0] dataMask;
  logic [24:0] retTag;

  int nChecks = 0, nFail = 0, cyc = 0;
  bit finished = 0;

  logic [2:0]  lType [NLOG];
  logic [1:0]  lBank [NLOG];
  logic [12:0] lAddr [NLOG];
  logic [7:0]  lMask [NLOG];
  logic        lPop  [NLOG];
  int          lCyc  [NLOG];
  int nCmd = 0;
  logic [24:0] rTag [NLOG];
  int          rCyc [NLOG];
  int nRet = 0;

  dram_txn_engine #(.TRCD(TRCD), .TRP(TRP), .TRAS(TRAS), .TRFC(TRFC), .TWR(TWR),
                    .TREFI(TREFI), .CL(CL)) i_dram_txn_engine (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqBursts(reqBursts), .reqReady(reqReady), .cmdCode(cmdCode), .cmdBank(cmdBank),
    .cmdAddr(cmdAddr), .dataMask(dataMask), .wrPop(wrPop), .retValid(retValid),
    .retTag(retTag));

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && cmdCode != 3'd0 && nCmd < NLOG) begin
      lType[nCmd] = cmdCode; lBank[nCmd] = cmdBank; lAddr[nCmd] = cmdAddr;
      lMask[nCmd] = dataMask; lPop[nCmd] = wrPop; lCyc[nCmd] = cyc;
      nCmd = nCmd + 1;
    end
    if (rstN && retValid && nRet < NLOG) begin
      rTag[nRet] = retTag; rCyc[nRet] = cyc;
      nRet = nRet + 1;
    end
  end

  task automatic chk(string req, string what, longint got, longint exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int firstCmd(int after);
    for (int i = 0; i < nCmd; i++) if (lCyc[i] > after) return i;
    return NLOG - 1;
  endfunction

  function automatic int firstRet(int after);
    for (int i = 0; i < nRet; i++) if (rCyc[i] > after) return i;
    return NLOG - 1;
  endfunction

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  task automatic send(logic [1:0] op, logic [24:0] a, logic [1:0] nb, output int acc);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; reqAddr = a; reqBursts = nb;
    while (!reqReady) @(negedge clk);
    acc = cyc;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R11", "cmdCode", cmdCode, 0);
    chk("R11", "reqReady", reqReady, 1);
    chk("R11", "retValid", retValid, 0);
    chk("R11", "wrPop", wrPop, 0);
    chk("R11", "dataMask", dataMask, 0);
  endtask

  task automatic testSingleRead(logic [24:0] a);
    int acc, c, r, actC, rdC;
    send(2'd0, a, 2'd3, acc);
    idle(50);
    c = firstCmd(acc);
    actC = acc + 1;
    chk("R2", "act type", lType[c], 1);
    chk("R2", "act cycle", lCyc[c], actC);
    chk("R1", "act bank", lBank[c], a[24:23]);
    chk("R1", "act row", lAddr[c], a[22:10]);
    rdC = actC + TRCD;
    chk("R3", "read type", lType[c+1], 2);
    chk("R3", "read cycle", lCyc[c+1], rdC);
    chk("R3", "read col", lAddr[c+1], {a[9:3], 3'b000});
    chk("R5", "pre type", lType[c+2], 4);
    chk("R5", "pre cycle", lCyc[c+2], maxi(actC + TRAS, rdC + BEAT));
    chk("R5", "pre bit10", lAddr[c+2][10], 0);
    chk("R5", "pre bank", lBank[c+2], a[24:23]);
    r = firstRet(acc);
    chk("R8", "single return count", nRet - r, 1);
    chk("R8", "return cycle", rCyc[r], rdC + CL);
    chk("R8", "return tag", rTag[r], a);
  endtask

  task automatic testSingleWrite(logic [24:0] a);
    int acc, c, wrC;
    logic [7:0] expMask;
    int r0;
    r0 = nRet;
    send(2'd1, a, 2'd2, acc);
    idle(50);
    c = firstCmd(acc);
    wrC = acc + 1 + TRCD;
    expMask = ~(8'd1 << a[2:0]);
    chk("R2", "act type", lType[c], 1);
    chk("R3", "write type", lType[c+1], 3);
    chk("R3", "write cycle", lCyc[c+1], wrC);
    chk("R7", "write pop", lPop[c+1], 1);
    chk("R7", "single write mask", lMask[c+1], expMask);
    chk("R5", "pre cycle after write", lCyc[c+2], maxi(acc + 1 + TRAS, wrC + BEAT + TWR));
    chk("R7", "pre mask zero", lMask[c+2], 0);
    chk("R8", "no return on write", nRet, r0);
  endtask

  task automatic testBlockRead(logic [24:0] a, logic [1:0] nb);
    int acc, c, r, rd0;
    logic [24:0] base;
    send(2'd2, a, nb, acc);
    idle(40 + 8 * (nb + 1));
    c = firstCmd(acc);
    base = {a[24:3], 3'b000};
    rd0 = acc + 1 + TRCD;
    for (int k = 0; k <= int'(nb); k++) begin
      chk("R4", "burst type", lType[c+1+k], 2);
      chk("R4", "burst cycle", lCyc[c+1+k], rd0 + BEAT * k);
      chk("R4", "burst col", lAddr[c+1+k], {3'b000, base[9:0] + 10'(BEAT * k)});
    end
    chk("R5", "pre after block read", lCyc[c+2+nb], maxi(acc + 1 + TRAS, rd0 + BEAT * nb + BEAT));
    r = firstRet(acc);
    chk("R8", "block return count", nRet - r, BEAT * (nb + 1));
    for (int i = 0; i < BEAT * (int'(nb) + 1); i++) begin
      chk("R8", "block ret cycle", rCyc[r+i], rd0 + CL + i);
      chk("R8", "block ret tag", rTag[r+i], base + 25'(i));
    end
  endtask

  task automatic testBlockWriteThenRead(logic [24:0] a, logic [24:0] b);
    int acc, acc2, c, wr0, preC, c2;
    send(2'd3, a, 2'd1, acc);
    send(2'd0, b, 2'd0, acc2);
    idle(50);
    c = firstCmd(acc);
    wr0 = acc + 1 + TRCD;
    for (int k = 0; k < 2; k++) begin
      chk("R4", "block write type", lType[c+1+k], 3);
      chk("R4", "block write cycle", lCyc[c+1+k], wr0 + BEAT * k);
      chk("R7", "block write mask", lMask[c+1+k], 0);
      chk("R7", "block write pop", lPop[c+1+k], 1);
    end
    preC = lCyc[c+3];
    chk("R5", "pre after block write", preC, wr0 + BEAT + BEAT + TWR);
    c2 = firstCmd(acc2);
    chk("R6", "act follows pre by trp", (lCyc[c2] - preC) >= TRP, 1);
    chk("R1", "second act bank", lBank[c2], b[24:23]);
  endtask

  task automatic testRefresh();
    int f, acc, c, k0, nr;
    int refC [3];
    k0 = nCmd;
    nr = 0;
    // wait for three REFRESH commands while idle
    while (nr < 3) begin
      @(negedge clk);
      if (cmdCode == 3'd5) begin
        refC[nr] = cyc;
        nr++;
      end
    end
    chk("R9", "idle refresh spacing", refC[2] - refC[1], TREFI);
    c = firstCmd(refC[1] - TRP - 1);
    chk("R9", "all-bank pre type", lType[c], 4);
    chk("R9", "all-bank pre bit10", lAddr[c][10], 1);
    chk("R9", "pre to refresh", refC[1] - lCyc[c], TRP);
    // request held through refresh busy time
    while (cmdCode != 3'd5) @(negedge clk);
    f = cyc;
    chk("R10", "ready low in refresh", reqReady, 0);
    send(2'd0, 25'h0, 2'd0, acc);
    chk("R10", "accept after trfc", acc - f, TRFC);
    idle(40);
    c = firstCmd(acc);
    chk("R10", "act after refresh", lCyc[c] - f, TRFC + 1);
    chk("R12", "log not overflowed", nCmd < NLOG, 1);
    if (k0 < 0) nFail++;
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    testReset();
    testSingleRead({2'd2, 13'h1A5C, 10'h2B3});
    testSingleWrite({2'd1, 13'h0F0F, 10'h0E6});
    testBlockRead({2'd3, 13'h0123, 10'h045}, 2'd3);
    testBlockRead({2'd0, 13'h1FFF, 10'h3F8}, 2'd0);
    testBlockWriteThenRead({2'd0, 13'h0042, 10'h110}, {2'd3, 13'h0007, 10'h001});
    testRefresh();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #(5 * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

endmodule